// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register File

This block holds the control state for one bank of general-purpose pins behind a plain 32-bit register bus. It keeps an output value register, a direction register and an output-enable register. From them it drives each pin's output level and its tristate enable. It also offers the bank's input pins to the bus after a two-flop synchroniser. The bank index is a parameter, and every register address is computed from it, so several instances can share one address decoder bus.

Software can change any single output pin in one write, with no read-modify-write and no race against other agents. Two write-only half-word ports each take a 16-bit mask in the upper half of the write data and 16 data bits in the lower half. Only the pins whose mask bit is 0 take their new value. A plain full-word output register is also provided and can be read back. A bank may be narrower than 32 pins; the missing bits read as zero and ignore writes.

Top module: `gpb_bank`

## Requirements
- R1: After a synchronous reset, the output, direction and output-enable registers are all zero. Every `pin_oe` bit is low, and every register except the input register reads 0.
- R2: A write to the low mask port at byte address 0x0 + 8*BANK_IDX changes output bit i (0..15) to wdata[i] when wdata[16+i] is 0. Bits whose mask is 1 keep their value.
- R3: A write to the high mask port at byte address 0x4 + 8*BANK_IDX changes output bit 16+i to wdata[i] when wdata[16+i] is 0. Bits whose mask is 1 keep their value.
- R4: The full-word output register at 0x40 + 4*BANK_IDX is read/write. A write replaces all output bits, and a read returns the current output register.
- R5: The input register at 0x60 + 4*BANK_IDX returns the pins after two flops. A read whose strobe cycle starts at the same edge that first samples a pin change still returns the old value. A read issued one cycle later returns the new value.
- R6: The direction register at 0x204 + 0x40*BANK_IDX is read/write (1 = output).
- R7: The output-enable register at 0x208 + 0x40*BANK_IDX is read/write. `pin_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1.
- R8: `pin_out` always equals the output register, whatever the direction and enable settings.
- R9: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high. It is 0 in every cycle that follows a cycle without a read.
- R10: Reads of the two mask ports return 0. Any other address reads 0, and a write to it leaves all registers unchanged.
- R11: Bits at positions NUM_PINS and above read 0 from every register and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Per-pin output level |
| pin_oe | output | NUM_PINS | Per-pin drive enable |

## Verification
Several properties are checked on every cycle: an all-ones mask leaves the outputs untouched, a cycle with no write holds all state, and a full-word write lands on the next cycle. The assertions also cover the two-cycle delay of the synchroniser, zero read data outside read cycles and from the mask ports, and zero upper bits on a narrow bank. Other behaviour only shows in the bench scenarios. These are the per-pin effect of every mask bit, the AND of direction and enable, and writes to a neighbouring bank's addresses being ignored. The bench sweeps every pin of a 32-pin bank and a 22-pin bank that share one bus.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_LO,
        SEL_MASK_HI,
        SEL_OUT_WORD,
        SEL_IN_WORD,
        SEL_DIR,
        SEL_OE
    } gpb_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] en;
        logic [WORD_W-1:0] val;
    } gpb_wr_s;

    function automatic int off_mask_lo(int bank);
        return 8 * bank;
    endfunction
    function automatic int off_mask_hi(int bank);
        return 4 + 8 * bank;
    endfunction
    function automatic int off_out_word(int bank);
        return 'h40 + 4 * bank;
    endfunction
    function automatic int off_in_word(int bank);
        return 'h60 + 4 * bank;
    endfunction
    function automatic int off_dir(int bank);
        return 'h204 + 'h40 * bank;
    endfunction
    function automatic int off_oe(int bank);
        return 'h208 + 'h40 * bank;
    endfunction

    // Per-bit update enables and values for the output register.
    function automatic gpb_wr_s out_write_vec(gpb_sel_e sel, logic [WORD_W-1:0] d);
        gpb_wr_s r;
        r.en  = '0;
        r.val = '0;
        case (sel)
            SEL_MASK_LO: begin
                r.en[HALF_W-1:0]  = ~d[WORD_W-1:HALF_W];
                r.val[HALF_W-1:0] = d[HALF_W-1:0];
            end
            SEL_MASK_HI: begin
                r.en[WORD_W-1:HALF_W]  = ~d[WORD_W-1:HALF_W];
                r.val[WORD_W-1:HALF_W] = d[HALF_W-1:0];
            end
            SEL_OUT_WORD: begin
                r.en  = '1;
                r.val = d;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANK_IDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output gpb_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(off_mask_lo(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(off_mask_hi(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(off_out_word(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(off_in_word(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(off_dir(BANK_IDX));
    localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(off_oe(BANK_IDX));

    always_comb begin
        if      (addr == A_LO)  sel = SEL_MASK_LO;
        else if (addr == A_HI)  sel = SEL_MASK_HI;
        else if (addr == A_OUT) sel = SEL_OUT_WORD;
        else if (addr == A_IN)  sel = SEL_IN_WORD;
        else if (addr == A_DIR) sel = SEL_DIR;
        else if (addr == A_OE)  sel = SEL_OE;
        else                    sel = SEL_NONE;
    end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end
    assign q = stage2_q;

    // Warm-up count so the two-cycle look-back never reaches into reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)              warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 2'd1;
    end

    a_r5_two_flop_delay: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  gpb_sel_e            sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] oe_q
);
    gpb_wr_s             wv;
    logic [NUM_PINS-1:0] out_d;

    always_comb wv = out_write_vec(wr ? sel : SEL_NONE, wdata);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_out_bit
        assign out_d[i] = wv.en[i] ? wv.val[i] : out_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
            oe_q  <= '0;
        end else begin
            out_q <= out_d;
            if (wr && sel == SEL_DIR) dir_q <= wdata[NUM_PINS-1:0];
            if (wr && sel == SEL_OE)  oe_q  <= wdata[NUM_PINS-1:0];
        end
    end

    a_r2_all_masked_holds: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_MASK_LO && wdata[31:16] == 16'hFFFF) |=> $stable(out_q));
    a_r3_all_masked_holds: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_MASK_HI && wdata[31:16] == 16'hFFFF) |=> $stable(out_q));
    a_r4_word_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_OUT_WORD) |=> (out_q == $past(wdata[NUM_PINS-1:0])));
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr || sel == SEL_NONE || sel == SEL_IN_WORD)
        |=> ($stable(out_q) && $stable(dir_q) && $stable(oe_q)));
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    parameter int BANK_IDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    gpb_sel_e            sel;
    logic [NUM_PINS-1:0] out_q, dir_q, oe_q, in_s;
    logic [31:0]         rd_mux;
    logic [31:0]         rdata_q;

    gpb_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpb_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .out_q (out_q),
        .dir_q (dir_q),
        .oe_q  (oe_q)
    );

    gpb_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_s)
    );

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_OUT_WORD: rd_mux[NUM_PINS-1:0] = out_q;
            SEL_IN_WORD:  rd_mux[NUM_PINS-1:0] = in_s;
            SEL_DIR:      rd_mux[NUM_PINS-1:0] = dir_q;
            SEL_OE:       rd_mux[NUM_PINS-1:0] = oe_q;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q & oe_q;

    a_r9_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'h0));
    a_r10_mask_port_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == SEL_MASK_LO || sel == SEL_MASK_HI || sel == SEL_NONE))
        |=> (bus_rdata == 32'h0));
    if (NUM_PINS < 32) begin : g_narrow_chk
        a_r11_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
            bus_rdata[31:NUM_PINS] == '0);
    end
endmodule

// File: tb/gpb_bank_tb_top.sv
module gpb_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] pins = '0;
    logic [31:0] rdata_w, rdata_n;
    logic [31:0] pout_w, poe_w;
    logic [21:0] pout_n, poe_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] m_out [2];
    logic [31:0] m_dir [2];
    logic [31:0] m_oe  [2];
    logic [31:0] m_in;

    always #10 clk = ~clk;

    gpb_bank #(.NUM_PINS(32), .ADDR_W(12), .BANK_IDX(0)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_w),
        .pin_in(pins), .pin_out(pout_w), .pin_oe(poe_w));

    gpb_bank #(.NUM_PINS(22), .ADDR_W(12), .BANK_IDX(1)) dut_n (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_n),
        .pin_in(pins[21:0]), .pin_out(pout_n), .pin_oe(poe_n));

    function automatic logic [31:0] wmask(int k);
        return (k == 0) ? 32'hFFFF_FFFF : 32'h003F_FFFF;
    endfunction

    function automatic logic [31:0] exp_rd(int k, logic [11:0] a);
        if (a == 12'(32'h40 + 4*k))   return m_out[k];
        if (a == 12'(32'h60 + 4*k))   return m_in & wmask(k);
        if (a == 12'(32'h204 + 64*k)) return m_dir[k];
        if (a == 12'(32'h208 + 64*k)) return m_oe[k];
        return 32'h0;
    endfunction

    task automatic model_wr(logic [11:0] a, logic [31:0] d);
        for (int k = 0; k < 2; k++) begin
            if (a == 12'(8*k)) begin
                for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[k][i] = d[i];
            end else if (a == 12'(4 + 8*k)) begin
                for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[k][16+i] = d[i];
            end else if (a == 12'(32'h40 + 4*k)) m_out[k] = d;
            else if (a == 12'(32'h204 + 64*k))   m_dir[k] = d;
            else if (a == 12'(32'h208 + 64*k))   m_oe[k] = d;
            m_out[k] &= wmask(k);
            m_dir[k] &= wmask(k);
            m_oe[k]  &= wmask(k);
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(string req, logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, rdata_w, exp_rd(0, a));
        chk(req, rdata_n, exp_rd(1, a));
    endtask

    task automatic pins_chk(string req);
        chk(req, pout_w, m_out[0]);
        chk(req, {10'h0, pout_n}, m_out[1]);
        chk(req, poe_w, m_dir[0] & m_oe[0]);
        chk(req, {10'h0, poe_n}, m_dir[1] & m_oe[1]);
    endtask

    task automatic rd_all(string req);
        for (int k = 0; k < 2; k++) begin
            rd_chk(req, 12'(32'h40 + 4*k));
            rd_chk(req, 12'(32'h204 + 64*k));
            rd_chk(req, 12'(32'h208 + 64*k));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_out[k] = '0; m_dir[k] = '0; m_oe[k] = '0;
        end
        m_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        pins_chk("R1");
        rd_all("R1");

        // R2/R3/R8: single-pin set then clear on each bank, every pin
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < (k == 0 ? 32 : 22); p++) begin
                logic [11:0] a;
                logic [31:0] one;
                a = 12'((p < 16 ? 0 : 4) + 8*k);
                one = 32'h1 << (p % 16);
                wr(a, {~one[15:0], one[15:0]});
                pins_chk(p < 16 ? "R2 set R8" : "R3 set R8");
                wr(a, {~one[15:0], 16'h0});
                pins_chk(p < 16 ? "R2 clear" : "R3 clear");
            end
        end

        // R2/R3: multi-bit masks with data on masked bits that must be ignored
        for (int j = 0; j < 6; j++) begin
            logic [31:0] v;
            v = 32'h9E37_79B9 * (j + 1);
            wr(12'h000, v);
            wr(12'h004, v ^ 32'h5A5A_0F0F);
            wr(12'h008, ~v);
            wr(12'h00C, {v[15:0], v[31:16]});
            pins_chk("R2 R3 pattern");
        end

        // R4/R11: full-word output register write and readback
        for (int j = 0; j < 4; j++) begin
            logic [31:0] v;
            v = 32'hC2B2_AE35 * (j + 3);
            wr(12'h040, v);
            wr(12'h044, ~v);
            pins_chk("R4 R8");
            rd_chk("R4", 12'h040);
            rd_chk("R4 R11", 12'h044);
        end

        // R6/R7/R11: direction and enable combinations
        for (int j = 0; j < 6; j++) begin
            logic [31:0] a, b;
            a = 32'h7F4A_7C15 * (j + 1);
            b = a ^ (a << 3) ^ 32'h0F0F_3C3C;
            wr(12'h204, a); wr(12'h208, b);
            wr(12'h244, b); wr(12'h248, a);
            pins_chk("R7");
            rd_chk("R6", 12'h204);
            rd_chk("R6 R11", 12'h244);
            rd_chk("R7", 12'h208);
            rd_chk("R7 R11", 12'h248);
        end

        // R5: input synchroniser latency and value
        for (int j = 0; j < 4; j++) begin
            logic [31:0] old_in;
            old_in = m_in;
            @(negedge clk);
            pins = 32'hA5C3_1E69 * (j + 5);
            rd_chk("R5 old value", 12'h060);   // model still holds old input
            m_in = pins;
            rd_chk("R5 new value", 12'h060);
            rd_chk("R5 R11", 12'h064);
            chk("R5 changed", {31'h0, old_in != m_in}, 32'h1);
        end

        // R10: mask ports and unmapped addresses read zero
        rd_chk("R10 mask lo", 12'h000);
        rd_chk("R10 mask hi", 12'h004);
        rd_chk("R10 mask hi b1", 12'h00C);
        rd_chk("R10 unmapped", 12'h100);
        rd_chk("R10 unmapped", 12'h041);

        // R10: writes to unmapped addresses leave everything unchanged
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h3FC, 32'h0000_FFFF);
        wr(12'h060, 32'hFFFF_FFFF);
        wr(12'h206, 32'hFFFF_FFFF);
        pins_chk("R10 no effect");
        rd_all("R10 no effect");

        // R9: no read strobe -> zero read data
        @(negedge clk);
        bus_addr = 12'h040;
        @(negedge clk);
        chk("R9 idle", rdata_w, 32'h0);
        chk("R9 idle", rdata_n, 32'h0);

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 2; k++) begin
            m_out[k] = '0; m_dir[k] = '0; m_oe[k] = '0;
        end
        pins_chk("R1 rereset");
        rd_all("R1 rereset");

        finish_run();
    end
endmodule